// File: doc/BRIEF.md
# Multiplexed GPIO Port with Edge Interrupts

This block is an eight-pin general-purpose I/O port with byte-wide software registers. Each pin is routed by a two-level function choice: a primary select bit and a secondary select bit. Together they pick one of four uses for the pin. It can be ordinary I/O, where the direction bit is honoured. It can carry a timer signal: a compare output when the direction bit is set, or a capture input when it is clear. It can belong to a serial unit, which then owns the pad's output enable. Or it can be a capacitive-sensing oscillator tap, where the direction bit has no effect.

Two overrides sit above the function choice. A per-pin analog-enable input switches the digital path of that pin off completely. A test-mode input takes over the upper four pins for boundary test access. Pad inputs pass through a two-flop synchronizer. Each pin can then raise its own interrupt flag on a chosen edge. All pins share one registered port interrupt request. All outputs of the block are registered.

Top module: `gpio_mux_port`

## Requirements
- R1: On synchronous reset, the output, direction, select, secondary-select, edge-select, enable, pull and flag registers clear to 0, so every pin starts as an input. After reset, pad_oe, pad_out, irq and rd_data are all 0.
- R2: The registers decode at these byte offsets: input 0x20, output 0x21, direction 0x22, flag 0x23, edge select 0x24, enable 0x25, primary select 0x26, pull enable 0x27, secondary select 0x41. A read returns the addressed register on rd_data one cycle after addr is presented. An unmapped offset reads 0. Writes to the input offset are ignored. The input register shows the synchronized pad value with overridden pins forced to 0.
- R3: With primary=0 and secondary=0 (plain I/O), the pin's pad_oe equals its direction bit and its pad_out equals its output-register bit, one cycle after the registers change.
- R4: With primary=1 and secondary=0 (timer), pad_out carries tmr_out and pad_oe equals the direction bit. When the direction bit is 0, tmr_cap carries the synchronized pad; otherwise tmr_cap is 0.
- R5: With primary=1 and secondary=1 (serial), pad_oe follows ser_oe and pad_out follows ser_out, whatever the direction bit is. ser_in carries the synchronized pad.
- R6: With primary=0 and secondary=1 (capacitive sensing), pad_oe is 0 whatever the direction bit is, and cs_in carries the synchronized pad.
- R7: When a pin's ana_en bit is 1, the following are all 0 for that pin one cycle later: its pad_oe, pad_out, tmr_cap, ser_in and cs_in bits, and its input-register bit.
- R8: While jtag_mode is 1, pins 4 to 7 behave as overridden in the same way as R7. Pins 0 to 3 keep their selected function.
- R9: A pad level change sampled at clock edge k sets the pin's flag at edge k+2. The change must be rising when the pin's edge-select bit is 0, or falling when it is 1. Flags do not clear on their own.
- R10: A write to the flag register loads the written byte. An edge detected in the same cycle still sets its flag. Writing the edge-select register never sets a flag by itself.
- R11: irq is 1 exactly when, one cycle earlier, some pin had both its flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset (write and read) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for addr |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| ana_en | input | 8 | Per-pin analog enable (digital path off) |
| jtag_mode | input | 1 | Test mode, takes pins 4 to 7 |
| tmr_out | input | 8 | Timer compare output per pin |
| tmr_cap | output | 8 | Timer capture input per pin |
| ser_out | input | 8 | Serial unit output data per pin |
| ser_oe | input | 8 | Serial unit output enable per pin |
| ser_in | output | 8 | Pad level routed to serial unit |
| cs_in | output | 8 | Pad level routed to sensing oscillator |
| irq | output | 1 | Combined port interrupt request |

## Verification
The bench builds the port with its default parameters: eight pins, a two-stage synchronizer, and the test-mode boundary at pin 4. With these values the test mode overrides exactly half the port, so a single stimulus shows both the taken pins and the untouched pins on pad_oe. The eight-bit width also lets every function mode be present on different pins in the random phase, with the analog overrides and edge polarities mixed per pin in the same cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // pin function, encoded as {primary select, secondary select}
  typedef enum logic [1:0] {
    FN_GPIO  = 2'b00,
    FN_SENSE = 2'b01,
    FN_TIMER = 2'b10,
    FN_SER   = 2'b11
  } pin_fn_e;

  localparam logic [7:0] OFS_IN    = 8'h20;
  localparam logic [7:0] OFS_OUT   = 8'h21;
  localparam logic [7:0] OFS_DIR   = 8'h22;
  localparam logic [7:0] OFS_FLAG  = 8'h23;
  localparam logic [7:0] OFS_EDGE  = 8'h24;
  localparam logic [7:0] OFS_IE    = 8'h25;
  localparam logic [7:0] OFS_SEL   = 8'h26;
  localparam logic [7:0] OFS_PULL  = 8'h27;
  localparam logic [7:0] OFS_SEL2  = 8'h41;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] falling_sel,
  input  logic             flag_wr,
  input  logic [WIDTH-1:0] flag_wdata,
  output logic [WIDTH-1:0] flag_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;

  always_comb begin
    hit = (level & ~prev_q & ~falling_sel) | (~level & prev_q & falling_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level;
      flag_q <= (flag_wr ? flag_wdata : flag_q) | hit;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pin_fn_e fn,
  input  logic    dir,
  input  logic    out_bit,
  input  logic    ovr,
  input  logic    pin_s,
  input  logic    tmr_o,
  input  logic    ser_o,
  input  logic    ser_en,
  output logic    pad_o,
  output logic    pad_en,
  output logic    cap_o,
  output logic    ser_i,
  output logic    cs_o
);
  logic n_pad, n_en, n_cap, n_ser, n_cs;

  always_comb begin
    n_pad = 1'b0;
    n_en  = 1'b0;
    n_cap = 1'b0;
    n_ser = 1'b0;
    n_cs  = 1'b0;
    if (!ovr) begin
      unique case (fn)
        FN_GPIO: begin
          n_pad = out_bit;
          n_en  = dir;
        end
        FN_TIMER: begin
          n_pad = tmr_o;
          n_en  = dir;
          n_cap = ~dir & pin_s;
        end
        FN_SER: begin
          n_pad = ser_o;
          n_en  = ser_en;
          n_ser = pin_s;
        end
        FN_SENSE: begin
          n_cs = pin_s;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_en <= 1'b0;
      cap_o  <= 1'b0;
      ser_i  <= 1'b0;
      cs_o   <= 1'b0;
    end else begin
      pad_o  <= n_pad;
      pad_en <= n_en;
      cap_o  <= n_cap;
      ser_i  <= n_ser;
      cs_o   <= n_cs;
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int JTAG_LO     = 4,
  parameter logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN),
  parameter logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT),
  parameter logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR),
  parameter logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG),
  parameter logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE),
  parameter logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFS_IE),
  parameter logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL),
  parameter logic [ADDR_W-1:0] A_PULL = ADDR_W'(OFS_PULL),
  parameter logic [ADDR_W-1:0] A_SEL2 = ADDR_W'(OFS_SEL2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  ana_en,
  input  logic              jtag_mode,
  input  logic [WIDTH-1:0]  tmr_out,
  output logic [WIDTH-1:0]  tmr_cap,
  input  logic [WIDTH-1:0]  ser_out,
  input  logic [WIDTH-1:0]  ser_oe,
  output logic [WIDTH-1:0]  ser_in,
  output logic [WIDTH-1:0]  cs_in,
  output logic              irq
);
  localparam logic [WIDTH-1:0] JTAG_MASK = {{(WIDTH-JTAG_LO){1'b1}}, {JTAG_LO{1'b0}}};

  logic [WIDTH-1:0] out_q, dir_q, edge_q, ie_q, sel_q, sel2_q, pull_q;
  logic [WIDTH-1:0] flag_q, pin_s, ovr, gated;
  logic [WIDTH-1:0] rd_next;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      edge_q <= '0;
      ie_q   <= '0;
      sel_q  <= '0;
      sel2_q <= '0;
      pull_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_OUT:  out_q  <= wr_data;
        A_DIR:  dir_q  <= wr_data;
        A_EDGE: edge_q <= wr_data;
        A_IE:   ie_q   <= wr_data;
        A_SEL:  sel_q  <= wr_data;
        A_SEL2: sel2_q <= wr_data;
        A_PULL: pull_q <= wr_data;
        default: ;
      endcase
    end
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_s)
  );

  assign ovr   = ana_en | (jtag_mode ? JTAG_MASK : '0);
  assign gated = pin_s & ~ovr;

  gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .level      (gated),
    .falling_sel(edge_q),
    .flag_wr    (wr_en && (addr == A_FLAG)),
    .flag_wdata (wr_data),
    .flag_q     (flag_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_mux u_mux (
      .clk    (clk),
      .rst    (rst),
      .fn     (pin_fn_e'({sel_q[i], sel2_q[i]})),
      .dir    (dir_q[i]),
      .out_bit(out_q[i]),
      .ovr    (ovr[i]),
      .pin_s  (pin_s[i]),
      .tmr_o  (tmr_out[i]),
      .ser_o  (ser_out[i]),
      .ser_en (ser_oe[i]),
      .pad_o  (pad_out[i]),
      .pad_en (pad_oe[i]),
      .cap_o  (tmr_cap[i]),
      .ser_i  (ser_in[i]),
      .cs_o   (cs_in[i])
    );
  end

  // read mux
  always_comb begin
    case (addr)
      A_IN:    rd_next = gated;
      A_OUT:   rd_next = out_q;
      A_DIR:   rd_next = dir_q;
      A_FLAG:  rd_next = flag_q;
      A_EDGE:  rd_next = edge_q;
      A_IE:    rd_next = ie_q;
      A_SEL:   rd_next = sel_q;
      A_PULL:  rd_next = pull_q;
      A_SEL2:  rd_next = sel2_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_next;
      irq     <= |(flag_q & ie_q);
    end
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int WIDTH   = 8,
  parameter int ADDR_W  = 8,
  parameter int JTAG_LO = 4,
  parameter logic [ADDR_W-1:0] A_FLAG = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  ana_en,
  input logic              jtag_mode,
  input logic [WIDTH-1:0]  pad_oe,
  input logic              irq,
  input logic [WIDTH-1:0]  flag_q,
  input logic [WIDTH-1:0]  ie_q,
  input logic [WIDTH-1:0]  sel_q,
  input logic [WIDTH-1:0]  sel2_q
);
  localparam logic [WIDTH-1:0] HI = {{(WIDTH-JTAG_LO){1'b1}}, {JTAG_LO{1'b0}}};

  assert_analog_oe_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(ana_en) & pad_oe) == '0));

  assert_jtag_oe_R8: assert property (@(posedge clk) disable iff (rst)
    $past(jtag_mode) |-> ((pad_oe & HI) == '0));

  assert_sense_oe_R6: assert property (@(posedge clk) disable iff (rst)
    (($past(~sel_q & sel2_q) & pad_oe) == '0));

  assert_irq_R11: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flag_q & ie_q)));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (|($past(flag_q) & ~flag_q)) |-> $past(wr_en && (addr == A_FLAG)));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .JTAG_LO(JTAG_LO), .A_FLAG(A_FLAG)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .ana_en(ana_en),
  .jtag_mode(jtag_mode), .pad_oe(pad_oe), .irq(irq), .flag_q(flag_q),
  .ie_q(ie_q), .sel_q(sel_q), .sel2_q(sel2_q)
);

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [7:0] addr = 0, wr_data = 0, pad_in = 0, ana_en = 0;
  logic       jtag_mode = 0;
  logic [7:0] tmr_out = 0, ser_out = 0, ser_oe = 0;
  logic [7:0] rd_data, pad_out, pad_oe, tmr_cap, ser_in, cs_in;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  gpio_mux_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ana_en(ana_en), .jtag_mode(jtag_mode), .tmr_out(tmr_out),
    .tmr_cap(tmr_cap), .ser_out(ser_out), .ser_oe(ser_oe), .ser_in(ser_in),
    .cs_in(cs_in), .irq(irq)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] padq[$];
  logic [7:0] m_s, m_prev, m_out, m_dir, m_ies, m_ie, m_sel, m_sel2, m_pull, m_flag;
  logic [7:0] e_pad, e_oe, e_cap, e_ser, e_cs, e_rd;
  logic       e_irq;

  always @(posedge clk) begin
    logic [7:0] ovr, g, hit, np, no, nc, ns, nx, nr;
    if (rst) begin
      padq = '{8'h00, 8'h00};
      {m_s, m_prev, m_out, m_dir, m_ies, m_ie, m_sel, m_sel2, m_pull, m_flag} = '0;
      {e_pad, e_oe, e_cap, e_ser, e_cs, e_rd} = '0;
      e_irq = 0;
    end else begin
      ovr = ana_en | (jtag_mode ? 8'hF0 : 8'h00);
      g = m_s & ~ovr;
      for (int i = 0; i < 8; i++) begin
        hit[i] = m_ies[i] ? (!g[i] && m_prev[i]) : (g[i] && !m_prev[i]);
        np[i] = 0; no[i] = 0; nc[i] = 0; ns[i] = 0; nx[i] = 0;
        if (!ovr[i]) begin
          if (!m_sel[i] && !m_sel2[i]) begin np[i] = m_out[i]; no[i] = m_dir[i]; end
          else if (m_sel[i] && !m_sel2[i]) begin
            np[i] = tmr_out[i]; no[i] = m_dir[i]; nc[i] = !m_dir[i] && m_s[i];
          end else if (m_sel[i] && m_sel2[i]) begin
            np[i] = ser_out[i]; no[i] = ser_oe[i]; ns[i] = m_s[i];
          end else nx[i] = m_s[i];
        end
      end
      case (addr)
        8'h20: nr = g;      8'h21: nr = m_out;  8'h22: nr = m_dir;
        8'h23: nr = m_flag; 8'h24: nr = m_ies;  8'h25: nr = m_ie;
        8'h26: nr = m_sel;  8'h27: nr = m_pull; 8'h41: nr = m_sel2;
        default: nr = 0;
      endcase
      e_irq = |(m_flag & m_ie);
      m_flag = ((wr_en && addr == 8'h23) ? wr_data : m_flag) | hit;
      if (wr_en) case (addr)
        8'h21: m_out = wr_data;  8'h22: m_dir = wr_data;
        8'h24: m_ies = wr_data;  8'h25: m_ie = wr_data;
        8'h26: m_sel = wr_data;  8'h27: m_pull = wr_data;
        8'h41: m_sel2 = wr_data;
        default: ;
      endcase
      m_prev = g;
      padq.push_front(pad_in);
      m_s = padq[1];
      if (padq.size() > 4) void'(padq.pop_back());
      e_pad = np; e_oe = no; e_cap = nc; e_ser = ns; e_cs = nx; e_rd = nr;
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (model_on) begin
      chk("R3", "pad_out", pad_out, e_pad);
      chk("R3", "pad_oe", pad_oe, e_oe);
      chk("R4", "tmr_cap", tmr_cap, e_cap);
      chk("R5", "ser_in", ser_in, e_ser);
      chk("R6", "cs_in", cs_in, e_cs);
      chk("R2", "rd_data", rd_data, e_rd);
      chk("R11", "irq", {7'b0, irq}, {7'b0, e_irq});
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst = 0;
    step(1);
    // r1_ reset state
    chk("R1", "pad_oe", pad_oe, 8'h00);
    chk("R1", "pad_out", pad_out, 8'h00);
    chk("R1", "irq", {7'b0, irq}, 8'h00);
    chk("R1", "rd_data", rd_data, 8'h00);
    model_on = 1;
    rd(8'h22, v); chk("R1", "dir reset", v, 8'h00);
    rd(8'h26, v); chk("R1", "sel reset", v, 8'h00);

    // R2 register map
    wr(8'h21, 8'hA5); wr(8'h22, 8'h0F); wr(8'h27, 8'h3C); wr(8'h24, 8'h00);
    rd(8'h21, v); chk("R2", "out reg", v, 8'hA5);
    rd(8'h22, v); chk("R2", "dir reg", v, 8'h0F);
    rd(8'h27, v); chk("R2", "pull reg", v, 8'h3C);
    rd(8'h30, v); chk("R2", "unmapped", v, 8'h00);
    wr(8'h20, 8'hFF);
    rd(8'h20, v); chk("R2", "input ignores write", v, 8'h00);

    // R3 plain I/O
    step(1);
    chk("R3", "pad_oe gpio", pad_oe, 8'h0F);
    chk("R3", "pad_out gpio", pad_out, 8'hA5);

    // R4 timer
    wr(8'h26, 8'hFF); tmr_out = 8'h3C; pad_in = 8'hCF;
    step(4);
    chk("R4", "pad_out timer", pad_out, 8'h3C);
    chk("R4", "pad_oe timer", pad_oe, 8'h0F);
    chk("R4", "tmr_cap", tmr_cap, 8'hC0);

    // R5 serial
    wr(8'h41, 8'hFF); ser_oe = 8'h55; ser_out = 8'hAA;
    step(2);
    chk("R5", "pad_oe serial", pad_oe, 8'h55);
    chk("R5", "pad_out serial", pad_out, 8'hAA);
    chk("R5", "ser_in", ser_in, 8'hCF);
    chk("R5", "tmr_cap off", tmr_cap, 8'h00);

    // R7 analog override
    ana_en = 8'h0F;
    step(2);
    chk("R7", "pad_oe analog", pad_oe, 8'h50);
    chk("R7", "pad_out analog", pad_out, 8'hA0);
    chk("R7", "ser_in analog", ser_in, 8'hC0);
    rd(8'h20, v); chk("R7", "input analog", v, 8'hC0);

    // R8 test mode
    ana_en = 8'h00; jtag_mode = 1;
    step(2);
    chk("R8", "pad_oe jtag", pad_oe, 8'h05);
    chk("R8", "ser_in jtag", ser_in, 8'h0F);
    rd(8'h20, v); chk("R8", "input jtag", v, 8'h0F);
    jtag_mode = 0;

    // R6 capacitive sensing
    wr(8'h26, 8'h00); wr(8'h22, 8'hFF);
    step(2);
    chk("R6", "pad_oe sense", pad_oe, 8'h00);
    chk("R6", "cs_in", cs_in, 8'hCF);
    chk("R6", "ser_in off", ser_in, 8'h00);

    // R9 edges
    wr(8'h41, 8'h00); wr(8'h22, 8'h00); pad_in = 8'h00;
    step(4);
    wr(8'h23, 8'h00);
    step(2);
    rd(8'h23, v); chk("R9", "flags cleared", v, 8'h00);
    pad_in = 8'h01; step(4);
    rd(8'h23, v); chk("R9", "rising flag", v, 8'h01);
    wr(8'h24, 8'h02);
    pad_in = 8'h03; step(4);
    rd(8'h23, v); chk("R9", "rising ignored on falling pin", v, 8'h01);
    pad_in = 8'h01; step(4);
    rd(8'h23, v); chk("R9", "falling flag", v, 8'h03);

    // R10 flag writes, edge-select write
    wr(8'h24, 8'hFF); step(2);
    rd(8'h23, v); chk("R10", "edge select write no flag", v, 8'h03);
    wr(8'h23, 8'h80); step(1);
    rd(8'h23, v); chk("R10", "flag load", v, 8'h80);

    // R11 interrupt request
    wr(8'h25, 8'h80); step(2);
    chk("R11", "irq on", {7'b0, irq}, 8'h01);
    wr(8'h25, 8'h7F); step(2);
    chk("R11", "irq off", {7'b0, irq}, 8'h00);

    // random phase against the model
    for (int c = 0; c < 600; c++) begin
      logic [7:0] alist [10] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h41, 8'h33};
      pad_in = $urandom; tmr_out = $urandom; ser_out = $urandom; ser_oe = $urandom;
      if ($urandom_range(0, 7) == 0) ana_en = $urandom;
      if ($urandom_range(0, 15) == 0) jtag_mode = ~jtag_mode;
      addr = alist[$urandom_range(0, 9)];
      wr_data = $urandom;
      wr_en = ($urandom_range(0, 3) == 0);
      step(1);
    end
    wr_en = 0;
    step(2);
    summary();
    $finish;
  end
endmodule